// File: doc/BRIEF.md
# Parallel Multiply-Add Status Flag Unit

This block builds the condition-code and exception-status bits for an instruction that runs a floating-point multiply (S1 times S2) and a floating-point add (S3 plus D2) in the same cycle. It sorts each source operand into zero, infinity, quiet NaN or signaling NaN. It takes the add result word and the inexact, overflow and underflow indicators from both datapaths, merges them, and writes one 16-bit status register. The multiplier, the adder and the rounding logic sit outside the block. Only their outputs come in.

One strobe, `upd_valid`, commits all the bits the instruction owns. Without it the register holds. Bits the instruction does not own keep their earlier values. Those bits can be loaded whole through `ext_wr`/`ext_val` by other instructions that share the register. The operand format is set by parameters, with IEEE-754 single precision as the default. A parameter also selects which value of the fraction MSB marks a quiet NaN.

Top module: `mpyadd_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all 16 status bits (`cc_out` and `er_out` read 0 on the cycle after reset).
- R2: When neither `upd_valid` nor `ext_wr` is high at a clock edge, every status bit keeps its value.
- R3: On an update, `cc_out[2]` (zero) is set when the add result has an all-zero exponent and fraction (either sign). `cc_out[3]` (negative) follows the add result's sign bit. `cc_out[4]` (infinity) is set when the exponent is all ones and the fraction is zero. Each is cleared otherwise.
- R4: On an update, `er_out[6]` (NaN) is set when the add result has an all-ones exponent and a nonzero fraction, and is cleared otherwise.
- R5: On an update, `er_out[0]` (inexact), `er_out[2]` (underflow) and `er_out[3]` (overflow) are each the OR of the matching multiply and add indicators.
- R6: On an update, `er_out[4]` (operand error) is set when one multiply operand is infinity and the other is zero, or when S3 and D2 are infinities of opposite sign. It is cleared otherwise.
- R7: On an update, `er_out[5]` (signaling NaN) is set when any of S1, S2, S3, D2 is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction MSB 0; a quiet NaN has fraction MSB 1. The bit is cleared otherwise.
- R8: On an update, `er_out[1]` (divide-by-zero) and `er_out[7]` (unordered) are always cleared.
- R9: On an update, `cc_out` bits 0, 1, 5, 6 and 7 (carry, overflow, limit, rounding, accumulator) keep their previous values.
- R10: `ext_wr` loads `{er_out, cc_out}` from `ext_val`. When it coincides with `upd_valid`, the update bits of R3 to R8 take priority and the held bits of R9 come from `ext_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Commit the flags of the multiply-add instruction |
| op_s1 | input | 32 | Multiply source operand 1 |
| op_s2 | input | 32 | Multiply source operand 2 |
| op_s3 | input | 32 | Add source operand |
| op_d2 | input | 32 | Add source/destination operand |
| add_res | input | 32 | Rounded add result word |
| mul_inexact | input | 1 | Multiply result inexact |
| mul_ovf | input | 1 | Multiply result overflow |
| mul_unf | input | 1 | Multiply result underflow |
| add_inexact | input | 1 | Add result inexact |
| add_ovf | input | 1 | Add result overflow |
| add_unf | input | 1 | Add result underflow |
| ext_wr | input | 1 | Load the whole status register |
| ext_val | input | 16 | Load value, `{er, cc}` |
| cc_out | output | 8 | Condition-code bits |
| er_out | output | 8 | Exception-status bits |

## Verification
The bench targets the operand-error cases. These cover infinity times zero in both operand orders, a negative zero, same-sign infinities that must not flag, and infinity times a finite value. A design that tested only one order, or compared signs wrongly, would flag valid adds or miss invalid ones. The bench places a signaling NaN in each of the four source slots and checks quiet NaNs separately, which exposes a swapped quiet/signaling convention or an operand left out of the check. It loads ones into the held condition bits before updates and collides a load with an update, so a design that cleared the held bits, or let the load override the update, shows a wrong register word. It also drives each exception indicator from one datapath alone, which catches flags that ignore one of the two operations.

// File: rtl/mafl_pkg.sv
package mafl_pkg;
   typedef struct packed {
      logic zero;
      logic inf;
      logic nan;
      logic snan;
   } opnd_class_t;

   // condition-code bit positions
   localparam int CC_CARRY = 0;
   localparam int CC_OVF   = 1;
   localparam int CC_ZERO  = 2;
   localparam int CC_NEG   = 3;
   localparam int CC_INF   = 4;
   localparam int CC_LIM   = 5;
   localparam int CC_RND   = 6;
   localparam int CC_ACC   = 7;

   // exception-status bit positions
   localparam int ER_INX   = 0;
   localparam int ER_DZ    = 1;
   localparam int ER_UNF   = 2;
   localparam int ER_OVF   = 3;
   localparam int ER_OPERR = 4;
   localparam int ER_SNAN  = 5;
   localparam int ER_NAN   = 6;
   localparam int ER_UNORD = 7;

   localparam int FLAG_W   = 8;

   // condition bits written by the multiply-add update
   localparam logic [FLAG_W-1:0] CC_OWNED_MASK =
      (8'd1 << CC_ZERO) | (8'd1 << CC_NEG) | (8'd1 << CC_INF);
endpackage

// File: rtl/mafl_classify.sv
module mafl_classify
   import mafl_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter bit QUIET_MSB = 1'b1
) (
   input  logic [EXP_W+FRAC_W-1:0] mag,
   output opnd_class_t             cls
);
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_ones;
   logic              exp_zero;
   logic              frac_zero;
   logic              quiet;

   assign expo      = mag[EXP_W+FRAC_W-1:FRAC_W];
   assign frac      = mag[FRAC_W-1:0];
   assign exp_ones  = &expo;
   assign exp_zero  = ~|expo;
   assign frac_zero = ~|frac;

   generate
      if (QUIET_MSB) begin : g_quiet_high
         assign quiet = frac[FRAC_W-1];
      end else begin : g_quiet_low
         assign quiet = ~frac[FRAC_W-1];
      end
   endgenerate

   assign cls.zero = exp_zero & frac_zero;
   assign cls.inf  = exp_ones & frac_zero;
   assign cls.nan  = exp_ones & ~frac_zero;
   assign cls.snan = exp_ones & ~frac_zero & ~quiet;
endmodule

// File: rtl/mafl_merge.sv
module mafl_merge
   import mafl_pkg::*;
#(
   parameter int N_OPND = 5
) (
   input  opnd_class_t       cls [N_OPND],
   input  logic              s3_sign,
   input  logic              d2_sign,
   input  logic              res_sign,
   input  logic              mul_inexact,
   input  logic              mul_ovf,
   input  logic              mul_unf,
   input  logic              add_inexact,
   input  logic              add_ovf,
   input  logic              add_unf,
   output logic [FLAG_W-1:0] cc_new,
   output logic [FLAG_W-1:0] er_new
);
   localparam int I_S1  = 0;
   localparam int I_S2  = 1;
   localparam int I_S3  = 2;
   localparam int I_D2  = 3;
   localparam int I_RES = 4;

   initial begin
      if (N_OPND != 5) $error("mafl_merge: N_OPND must be 5");
   end

   logic mul_invalid;
   logic add_invalid;
   logic src_snan;

   assign mul_invalid = (cls[I_S1].inf & cls[I_S2].zero) |
                        (cls[I_S1].zero & cls[I_S2].inf);
   assign add_invalid = cls[I_S3].inf & cls[I_D2].inf & (s3_sign ^ d2_sign);
   assign src_snan    = cls[I_S1].snan | cls[I_S2].snan |
                        cls[I_S3].snan | cls[I_D2].snan;

   always_comb begin
      cc_new           = '0;
      cc_new[CC_ZERO]  = cls[I_RES].zero;
      cc_new[CC_NEG]   = res_sign;
      cc_new[CC_INF]   = cls[I_RES].inf;

      er_new           = '0;
      er_new[ER_INX]   = mul_inexact | add_inexact;
      er_new[ER_UNF]   = mul_unf | add_unf;
      er_new[ER_OVF]   = mul_ovf | add_ovf;
      er_new[ER_OPERR] = mul_invalid | add_invalid;
      er_new[ER_SNAN]  = src_snan;
      er_new[ER_NAN]   = cls[I_RES].nan;
   end

   // classes from separate classifiers must be mutually exclusive (R3, R7)
   for (genvar i = 0; i < N_OPND; i++) begin : g_cls_chk
      always_comb begin
         assert_class_excl_R3: assert ($onehot0({cls[i].zero, cls[i].inf, cls[i].nan}));
         assert_snan_is_nan_R7: assert (!cls[i].snan || cls[i].nan);
      end
   end
endmodule

// File: rtl/mpyadd_flag_unit.sv
module mpyadd_flag_unit
   import mafl_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter bit QUIET_MSB = 1'b1,
   localparam int WORD_W   = 1 + EXP_W + FRAC_W,
   localparam int MAG_W    = EXP_W + FRAC_W,
   localparam int STAT_W   = 2 * FLAG_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_valid,
   input  logic [WORD_W-1:0] op_s1,
   input  logic [WORD_W-1:0] op_s2,
   input  logic [WORD_W-1:0] op_s3,
   input  logic [WORD_W-1:0] op_d2,
   input  logic [WORD_W-1:0] add_res,
   input  logic              mul_inexact,
   input  logic              mul_ovf,
   input  logic              mul_unf,
   input  logic              add_inexact,
   input  logic              add_ovf,
   input  logic              add_unf,
   input  logic              ext_wr,
   input  logic [STAT_W-1:0] ext_val,
   output logic [FLAG_W-1:0] cc_out,
   output logic [FLAG_W-1:0] er_out
);
   localparam int N_OPND = 5;

   initial begin
      if (EXP_W < 2)  $error("mpyadd_flag_unit: EXP_W must be at least 2");
      if (FRAC_W < 2) $error("mpyadd_flag_unit: FRAC_W must be at least 2");
   end

   logic [WORD_W-1:0] words [N_OPND];
   opnd_class_t       cls   [N_OPND];
   logic [FLAG_W-1:0] cc_new, er_new;
   logic [FLAG_W-1:0] cc_q, er_q, cc_d, er_d;

   assign words[0] = op_s1;
   assign words[1] = op_s2;
   assign words[2] = op_s3;
   assign words[3] = op_d2;
   assign words[4] = add_res;

   for (genvar i = 0; i < N_OPND; i++) begin : g_cls
      mafl_classify #(
         .EXP_W     (EXP_W),
         .FRAC_W    (FRAC_W),
         .QUIET_MSB (QUIET_MSB)
      ) u_cls (
         .mag (words[i][MAG_W-1:0]),
         .cls (cls[i])
      );
   end

   mafl_merge #(.N_OPND(N_OPND)) u_merge (
      .cls         (cls),
      .s3_sign     (op_s3[WORD_W-1]),
      .d2_sign     (op_d2[WORD_W-1]),
      .res_sign    (add_res[WORD_W-1]),
      .mul_inexact (mul_inexact),
      .mul_ovf     (mul_ovf),
      .mul_unf     (mul_unf),
      .add_inexact (add_inexact),
      .add_ovf     (add_ovf),
      .add_unf     (add_unf),
      .cc_new      (cc_new),
      .er_new      (er_new)
   );

   always_comb begin
      cc_d = cc_q;
      er_d = er_q;
      if (ext_wr) begin
         cc_d = ext_val[FLAG_W-1:0];
         er_d = ext_val[STAT_W-1:FLAG_W];
      end
      if (upd_valid) begin
         cc_d = (cc_d & ~CC_OWNED_MASK) | (cc_new & CC_OWNED_MASK);
         er_d = er_new;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cc_q <= '0;
         er_q <= '0;
      end else begin
         cc_q <= cc_d;
         er_q <= er_d;
      end
   end

   assign cc_out = cc_q;
   assign er_out = er_q;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (cc_out == '0 && er_out == '0));

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
      (!upd_valid && !ext_wr) |=> ($stable(cc_out) && $stable(er_out)));

   assert_zero_inf_excl_R3: assert property (@(posedge clk) disable iff (rst)
      upd_valid |=> !(cc_out[CC_ZERO] && cc_out[CC_INF]));

   assert_nan_not_zero_R4: assert property (@(posedge clk) disable iff (rst)
      upd_valid |=> !(er_out[ER_NAN] && (cc_out[CC_ZERO] || cc_out[CC_INF])));

   assert_dz_unord_clear_R8: assert property (@(posedge clk) disable iff (rst)
      upd_valid |=> (!er_out[ER_DZ] && !er_out[ER_UNORD]));

   assert_held_bits_R9: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && !ext_wr) |=>
         ((cc_out & ~CC_OWNED_MASK) == ($past(cc_out) & ~CC_OWNED_MASK)));

   assert_ext_load_R10: assert property (@(posedge clk) disable iff (rst)
      (ext_wr && !upd_valid) |=> ({er_out, cc_out} == $past(ext_val)));
endmodule

// File: tb/mpyadd_flag_unit_test.sv
module mpyadd_flag_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        upd_valid;
   logic [31:0] op_s1, op_s2, op_s3, op_d2, add_res;
   logic        mul_inexact, mul_ovf, mul_unf;
   logic        add_inexact, add_ovf, add_unf;
   logic        ext_wr;
   logic [15:0] ext_val;
   logic [7:0]  cc_out, er_out;

   int n_checks = 0;
   int n_fail   = 0;

   // expected register, {er, cc}
   logic [15:0] model;

   localparam logic [31:0] PZERO = 32'h0000_0000;
   localparam logic [31:0] NZERO = 32'h8000_0000;
   localparam logic [31:0] PINF  = 32'h7F80_0000;
   localparam logic [31:0] NINF  = 32'hFF80_0000;
   localparam logic [31:0] QNAN  = 32'h7FC0_0000;
   localparam logic [31:0] SNAN  = 32'h7FA0_0000;
   localparam logic [31:0] ONE   = 32'h3F80_0000;
   localparam logic [31:0] MTWO  = 32'hC000_0000;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpyadd_flag_unit uut (
      .clk(clk), .rst(rst), .upd_valid(upd_valid),
      .op_s1(op_s1), .op_s2(op_s2), .op_s3(op_s3), .op_d2(op_d2),
      .add_res(add_res),
      .mul_inexact(mul_inexact), .mul_ovf(mul_ovf), .mul_unf(mul_unf),
      .add_inexact(add_inexact), .add_ovf(add_ovf), .add_unf(add_unf),
      .ext_wr(ext_wr), .ext_val(ext_val),
      .cc_out(cc_out), .er_out(er_out)
   );

   function automatic bit f_inf(input logic [31:0] w);
      return (w[30:23] == 8'hFF) && (w[22:0] == 23'd0);
   endfunction
   function automatic bit f_zero(input logic [31:0] w);
      return w[30:0] == 31'd0;
   endfunction
   function automatic bit f_nan(input logic [31:0] w);
      return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
   endfunction
   function automatic bit f_snan(input logic [31:0] w);
      return f_nan(w) && !w[22];
   endfunction

   // expected result of one update applied to register value prev
   function automatic logic [15:0] expect_upd(input logic [15:0] prev);
      logic [7:0] cc, er;
      cc = prev[7:0];
      er = 8'd0;
      cc[2] = f_zero(add_res);
      cc[3] = add_res[31];
      cc[4] = f_inf(add_res);
      er[0] = mul_inexact | add_inexact;
      er[2] = mul_unf | add_unf;
      er[3] = mul_ovf | add_ovf;
      er[4] = (f_inf(op_s1) && f_zero(op_s2)) || (f_zero(op_s1) && f_inf(op_s2)) ||
              (f_inf(op_s3) && f_inf(op_d2) && (op_s3[31] != op_d2[31]));
      er[5] = f_snan(op_s1) | f_snan(op_s2) | f_snan(op_s3) | f_snan(op_d2);
      er[6] = f_nan(add_res);
      return {er, cc};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_ops(input logic [31:0] s1, s2, s3, d2, res,
                          input logic [5:0] ind);
      op_s1 = s1; op_s2 = s2; op_s3 = s3; op_d2 = d2; add_res = res;
      {mul_inexact, mul_ovf, mul_unf, add_inexact, add_ovf, add_unf} = ind;
   endtask

   // one update cycle; check full register against model
   task automatic run_upd(input string tag, input logic [31:0] s1, s2, s3, d2, res,
                          input logic [5:0] ind);
      @(negedge clk);
      set_ops(s1, s2, s3, d2, res, ind);
      upd_valid = 1'b1;
      model = expect_upd(model);
      @(negedge clk);
      upd_valid = 1'b0;
      chk(tag, {er_out, cc_out}, model);
   endtask

   task automatic load_reg(input logic [15:0] v);
      @(negedge clk);
      ext_wr = 1'b1; ext_val = v;
      @(negedge clk);
      ext_wr = 1'b0;
      model = v;
      chk("R10 load", {er_out, cc_out}, v);
   endtask

   task automatic t_reset;
      rst = 1'b1; upd_valid = 1'b0; ext_wr = 1'b0; ext_val = '0;
      set_ops(ONE, ONE, ONE, ONE, ONE, 6'd0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model = '0;
      chk("R1 reset", {er_out, cc_out}, 16'h0000);
   endtask

   task automatic t_held_bits;
      load_reg(16'hFFFF);
      run_upd("R9 held bits, R8 dz/unord", ONE, ONE, ONE, ONE, ONE, 6'd0);
      chk("R9 cc held = E3", {8'h00, cc_out}, 16'h00E3);
   endtask

   task automatic t_cond_codes;
      run_upd("R3 pos zero",  ONE, ONE, ONE, ONE, PZERO, 6'd0);
      run_upd("R3 neg zero",  ONE, ONE, ONE, ONE, NZERO, 6'd0);
      run_upd("R3 negative",  ONE, ONE, ONE, ONE, MTWO, 6'd0);
      run_upd("R3 infinity",  ONE, ONE, ONE, ONE, NINF, 6'd0);
      run_upd("R4 quiet nan", ONE, ONE, ONE, ONE, QNAN, 6'd0);
      run_upd("R4 sig nan res", ONE, ONE, ONE, ONE, SNAN, 6'd0);
   endtask

   task automatic t_exc_or;
      run_upd("R5 mul inexact", ONE, ONE, ONE, ONE, ONE, 6'b100_000);
      run_upd("R5 mul ovf",     ONE, ONE, ONE, ONE, ONE, 6'b010_000);
      run_upd("R5 mul unf",     ONE, ONE, ONE, ONE, ONE, 6'b001_000);
      run_upd("R5 add inexact", ONE, ONE, ONE, ONE, ONE, 6'b000_100);
      run_upd("R5 add ovf",     ONE, ONE, ONE, ONE, ONE, 6'b000_010);
      run_upd("R5 add unf",     ONE, ONE, ONE, ONE, ONE, 6'b000_001);
      run_upd("R5 clear",       ONE, ONE, ONE, ONE, ONE, 6'd0);
   endtask

   task automatic t_operr;
      run_upd("R6 inf*zero",      PINF,  PZERO, ONE, ONE, ONE, 6'd0);
      run_upd("R6 -zero*inf",     NZERO, NINF,  ONE, ONE, ONE, 6'd0);
      run_upd("R6 inf*finite",    PINF,  ONE,   ONE, ONE, ONE, 6'd0);
      run_upd("R6 +inf + -inf",   ONE,   ONE,  PINF, NINF, QNAN, 6'd0);
      run_upd("R6 -inf + +inf",   ONE,   ONE,  NINF, PINF, QNAN, 6'd0);
      run_upd("R6 same sign inf", ONE,   ONE,  PINF, PINF, PINF, 6'd0);
   endtask

   task automatic t_snan;
      run_upd("R7 snan s1",  SNAN, ONE, ONE, ONE, QNAN, 6'd0);
      run_upd("R7 snan s2",  ONE, SNAN, ONE, ONE, QNAN, 6'd0);
      run_upd("R7 snan s3",  ONE, ONE, SNAN, ONE, QNAN, 6'd0);
      run_upd("R7 snan d2",  ONE, ONE, ONE, SNAN, QNAN, 6'd0);
      run_upd("R7 qnan only", QNAN, QNAN, QNAN, QNAN, QNAN, 6'd0);
   endtask

   task automatic t_hold;
      run_upd("R2 setup", PINF, PZERO, ONE, ONE, NINF, 6'b111_111);
      @(negedge clk);
      set_ops(ONE, ONE, ONE, ONE, PZERO, 6'd0);
      ext_val = 16'h0000;
      repeat (3) @(negedge clk);
      chk("R2 hold without strobe", {er_out, cc_out}, model);
   endtask

   task automatic t_collide;
      @(negedge clk);
      set_ops(ONE, ONE, ONE, ONE, PZERO, 6'd0);
      ext_wr = 1'b1; ext_val = 16'hFFFF; upd_valid = 1'b1;
      model = expect_upd(16'hFFFF);
      @(negedge clk);
      ext_wr = 1'b0; upd_valid = 1'b0;
      chk("R10 update beats load", {er_out, cc_out}, model);
      chk("R10 expected E7", {er_out, cc_out}, 16'h00E7);
   endtask

   initial begin
      rst = 1'b1; upd_valid = 1'b0; ext_wr = 1'b0; ext_val = '0;
      set_ops(ONE, ONE, ONE, ONE, ONE, 6'd0);
      model = '0;
      t_reset();
      t_held_bits();
      t_cond_codes();
      t_exc_or();
      t_operr();
      t_snan();
      t_hold();
      t_collide();
      load_reg(16'h5A3C);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule